// File: doc/BRIEF.md
# Register-Triggered Memory Access Bridge

This block lets a host that only has a simple register port move words to and from a word-addressed memory bus. The host fills a write staging buffer through its register port and sets a transfer length. Writing a memory address into one of two launch registers then starts the transaction: one register starts a memory write, the other a memory read. The bridge then walks the memory bus one word at a time, incrementing the byte address by 4 per word.

While the transaction runs, a completion flag in the status register reads 0. The host polls it. When it returns to 1, read results sit in a capture buffer that the host reads through a window of register offsets. The version register tells the host the longest burst the bridge accepts. The memory side is a request/acknowledge port: the bridge holds one request until it sees an acknowledge, so memory may stall for any number of cycles.

Top module: `host_mem_bridge`

## Requirements
- R1: Register map in dword offsets: status 0x00, size 0x02, version 0x03, read-launch 0x04, write-launch 0x08, capture buffer 0x80..0xBF, staging buffer 0xC0..0xFF. Read data appears on `host_rdata` after the clock edge that samples `host_rd`. The size register reads back the last value written and is 0 after reset. The version register reads `(DEPTH << 4) | VER_LOW`, which is 0x402 by default.
- R2: A write to the write-launch register with value A sends staging-buffer entries 0, 1, 2, ... to memory words at A, A+4, A+8, ... with `mem_we` = 1.
- R3: A write to the read-launch register with value A reads memory words A, A+4, ... with `mem_we` = 0. It stores them in capture-buffer entries 0, 1, 2, ..., which are readable at dword offsets 0x80, 0x81, ...
- R4: A size of 0 gives exactly one memory beat. A size of N, with 1 <= N <= DEPTH, gives exactly N beats.
- R5: Within a transaction, each beat's `mem_addr` is the previous beat's address plus 4.
- R6: Status bit 0 is 1 after reset. It returns to 1 once the last beat of a transaction has been acknowledged, and memory requests stop at that point.
- R7: Status bit 0 goes to 0 at the same clock edge that accepts a launch-register write, so a status read issued on the next cycle returns 0.
- R8: A size above DEPTH (64) is clamped, and the transaction moves exactly DEPTH words.
- R9: `mem_req`, `mem_addr` and `mem_we` hold steady from the cycle a request is raised until `mem_ack` is seen, whatever the number of wait states.
- R10: A write to either launch register while a transaction is in progress has no effect. The running transaction keeps its address and length, and no further transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_off | input | 8 | Host register dword offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| mem_req | output | 1 | Memory request, one word per request |
| mem_we | output | 1 | 1 for a memory write beat |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge for the current beat |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
On every cycle the assertions check the following:
- the memory request stays steady across wait states;
- addresses advance by 4 between consecutive beats;
- a launch clears the completion flag and raises a request on the next cycle;
- a launch-register write during a transfer leaves the request untouched;
- requests end only with the flag set;
- each finished transaction carried the clamped beat count of the size that launched it.

Only the bench scenarios can show that the right data reaches the right memory word and capture-buffer entry. The same holds for register readback values, the status seen by a polling host, and the absence of a stray transaction after an ignored launch.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    localparam int HOST_OFF_W = 8;
    localparam int WORD_W     = 32;

    localparam logic [HOST_OFF_W-1:0] OFF_STATUS  = 8'h00;
    localparam logic [HOST_OFF_W-1:0] OFF_SIZE    = 8'h02;
    localparam logic [HOST_OFF_W-1:0] OFF_VERSION = 8'h03;
    localparam logic [HOST_OFF_W-1:0] OFF_RLAUNCH = 8'h04;
    localparam logic [HOST_OFF_W-1:0] OFF_WLAUNCH = 8'h08;
    localparam logic [HOST_OFF_W-1:0] OFF_CAPBUF  = 8'h80;
    localparam logic [HOST_OFF_W-1:0] OFF_STGBUF  = 8'hC0;

    localparam logic [WORD_W-1:0] ADDR_STRIDE = 32'd4;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_XFER
    } seq_state_e;

    typedef struct packed {
        logic              is_write;
        logic [WORD_W-1:0] addr;
    } launch_t;

    // Number of beats a size value asks for, clamped to the buffer depth.
    function automatic logic [15:0] beats_for(input logic [WORD_W-1:0] size,
                                              input int unsigned depth);
        if (size == '0)
            return 16'd1;
        else if (size > WORD_W'(depth))
            return 16'(depth);
        else
            return size[15:0];
    endfunction

    // True when a host offset falls inside a buffer window.
    function automatic logic in_window(input logic [HOST_OFF_W-1:0] off,
                                       input logic [HOST_OFF_W-1:0] base,
                                       input int unsigned depth);
        return (int'(off) >= int'(base)) && (int'(off) < int'(base) + int'(depth));
    endfunction

endpackage

// File: rtl/mbr_wordbuf.sv
module mbr_wordbuf #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            store[wr_idx] <= wr_data;
    end

    assign rd_data = store[rd_idx];

endmodule

// File: rtl/mbr_sequencer.sv
module mbr_sequencer
    import mbr_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  launch_t           launch_cmd,
    input  logic [CNT_W-1:0]  launch_beats,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  beat_idx,
    input  logic [WORD_W-1:0] src_data,
    output logic              cap_we,
    output logic [WORD_W-1:0] cap_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);

    seq_state_e        state_q;
    logic [WORD_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wr_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b1;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (launch) begin
                        state_q <= SEQ_XFER;
                        addr_q  <= launch_cmd.addr;
                        wr_q    <= launch_cmd.is_write;
                        left_q  <= launch_beats;
                        idx_q   <= '0;
                        done_q  <= 1'b0;
                    end
                end
                SEQ_XFER: begin
                    if (mem_ack) begin
                        addr_q <= addr_q + ADDR_STRIDE;
                        idx_q  <= idx_q + 1'b1;
                        left_q <= left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            state_q <= SEQ_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == SEQ_XFER);
    assign done      = done_q;
    assign beat_idx  = idx_q;
    assign mem_req   = busy;
    assign mem_we    = busy & wr_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = src_data;
    assign cap_we    = busy & ~wr_q & mem_ack;
    assign cap_data  = mem_rdata;

endmodule

// File: rtl/host_mem_bridge.sv
module host_mem_bridge
    import mbr_pkg::*;
#(
    parameter int          DEPTH   = 64,
    parameter logic [3:0]  VER_LOW = 4'h2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  host_off,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [WORD_W-1:0] VERSION_WORD = (WORD_W'(DEPTH) << 4) | WORD_W'(VER_LOW);

    logic [WORD_W-1:0] size_q;
    logic              seq_busy;
    logic              seq_done;
    logic [IDX_W-1:0]  beat_idx;
    logic [WORD_W-1:0] stg_rd;
    logic [WORD_W-1:0] cap_rd;
    logic              cap_we;
    logic [WORD_W-1:0] cap_data;
    logic              hit_rlaunch;
    logic              hit_wlaunch;
    logic              launch;
    launch_t           launch_cmd;
    logic [CNT_W-1:0]  launch_beats;
    logic              stg_we;
    logic [WORD_W-1:0] rd_mux;

    assign hit_rlaunch  = host_wr && (host_off == OFF_RLAUNCH);
    assign hit_wlaunch  = host_wr && (host_off == OFF_WLAUNCH);
    assign launch       = (hit_rlaunch || hit_wlaunch) && !seq_busy;
    assign launch_cmd   = '{is_write: hit_wlaunch, addr: host_wdata};
    assign launch_beats = CNT_W'(beats_for(size_q, DEPTH));
    assign stg_we       = host_wr && in_window(host_off, OFF_STGBUF, DEPTH);

    always_ff @(posedge clk) begin
        if (rst)
            size_q <= '0;
        else if (host_wr && host_off == OFF_SIZE)
            size_q <= host_wdata;
    end

    mbr_wordbuf #(.DEPTH(DEPTH), .DW(WORD_W)) u_stage_buf (
        .clk     (clk),
        .wr_en   (stg_we),
        .wr_idx  (host_off[IDX_W-1:0]),
        .wr_data (host_wdata),
        .rd_idx  (beat_idx),
        .rd_data (stg_rd)
    );

    mbr_wordbuf #(.DEPTH(DEPTH), .DW(WORD_W)) u_capture_buf (
        .clk     (clk),
        .wr_en   (cap_we),
        .wr_idx  (beat_idx),
        .wr_data (cap_data),
        .rd_idx  (host_off[IDX_W-1:0]),
        .rd_data (cap_rd)
    );

    mbr_sequencer #(.DEPTH(DEPTH)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .launch_cmd   (launch_cmd),
        .launch_beats (launch_beats),
        .busy         (seq_busy),
        .done         (seq_done),
        .beat_idx     (beat_idx),
        .src_data     (stg_rd),
        .cap_we       (cap_we),
        .cap_data     (cap_data),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata)
    );

    always_comb begin
        rd_mux = '0;
        if (host_off == OFF_STATUS)
            rd_mux = {{(WORD_W-1){1'b0}}, seq_done};
        else if (host_off == OFF_SIZE)
            rd_mux = size_q;
        else if (host_off == OFF_VERSION)
            rd_mux = VERSION_WORD;
        else if (in_window(host_off, OFF_CAPBUF, DEPTH))
            rd_mux = cap_rd;
    end

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (host_rd)
            host_rdata <= rd_mux;
    end

endmodule

// File: rtl/mbr_checker.sv
module mbr_checker
    import mbr_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  host_off,
    input logic        host_wr,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        seq_done,
    input logic [31:0] size_q
);

    logic        launch_wr;
    logic [15:0] beats_expected;
    logic [15:0] beats_seen;

    assign launch_wr = host_wr && (host_off == OFF_RLAUNCH || host_off == OFF_WLAUNCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_expected <= '0;
            beats_seen     <= '0;
        end else if (launch_wr && !mem_req) begin
            beats_expected <= beats_for(size_q, DEPTH);
            beats_seen     <= '0;
        end else if (mem_req && mem_ack) begin
            beats_seen <= beats_seen + 16'd1;
        end
    end

    assert_beats_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_done) |-> (beats_seen == beats_expected));

    assert_stride_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + 32'd4));

    assert_req_ends_done_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_req) |-> seq_done);

    assert_launch_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (launch_wr && !mem_req) |=> (mem_req && !seq_done));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && launch_wr) |=> (mem_req && $stable(mem_addr)));

endmodule

bind host_mem_bridge mbr_checker #(.DEPTH(DEPTH)) u_mbr_checker (
    .clk      (clk),
    .rst      (rst),
    .host_off (host_off),
    .host_wr  (host_wr),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .seq_done (seq_done),
    .size_q   (size_q)
);

// File: tb/host_mem_bridge_bench.sv
module host_mem_bridge_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  host_off = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    host_mem_bridge u_host_mem_bridge (
        .clk(clk), .rst(rst), .host_off(host_off), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model: 256 words indexed by address bits 9:2
    logic [31:0] mem [256];
    logic        valid [256];
    logic [31:0] addr_log [512];
    logic        we_log [512];
    int          beat_total = 0;
    int          wcnt = 0;
    int          wait_cfg = 0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'hC0DE_0000;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
            for (int i = 0; i < 256; i++) valid[i] <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt >= wait_cfg) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
                addr_log[beat_total % 512] <= mem_addr;
                we_log[beat_total % 512]   <= mem_we;
                beat_total <= beat_total + 1;
                mem_rdata <= valid[mem_addr[9:2]] ? mem[mem_addr[9:2]] : pat(mem_addr);
                if (mem_we) begin
                    mem[mem_addr[9:2]]   <= mem_wdata;
                    valid[mem_addr[9:2]] <= 1'b1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Tasks start and end at a falling edge
    task automatic host_write(input logic [7:0] off, input logic [31:0] d);
        host_off = off; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] off, output logic [31:0] d);
        host_off = off; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        int polls = 0;
        s = 0;
        while (s[0] !== 1'b1 && polls < 2000) begin
            host_read(8'h00, s);
            polls++;
        end
        chk(req, {31'b0, s[0]}, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        host_read(8'h00, d); chk("R6 status after reset", d, 32'd1);
        host_read(8'h03, d); chk("R1 version", d, 32'h0000_0402);
        host_read(8'h02, d); chk("R1 size after reset", d, 32'd0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        int b0;
        wait_cfg = 1;
        host_write(8'hC0, 32'h1234_5678);
        host_write(8'h02, 32'd0);
        b0 = beat_total;
        host_write(8'h08, 32'hA000_0000);
        wait_done("R6 single write done");
        chk("R4 single write beats", beat_total - b0, 32'd1);
        chk("R2 single write addr", addr_log[b0 % 512], 32'hA000_0000);
        chk("R2 single write we", {31'b0, we_log[b0 % 512]}, 32'd1);
        chk("R2 single write data", mem[0], 32'h1234_5678);
        host_write(8'h04, 32'hA000_0000);
        wait_done("R6 single read done");
        host_read(8'h80, d); chk("R3 single read data", d, 32'h1234_5678);
    endtask

    task automatic t_burst();
        logic [31:0] d;
        int b0;
        wait_cfg = 2;
        for (int i = 0; i < 8; i++) host_write(8'hC0 + 8'(i), 32'h1000 + i);
        host_write(8'h02, 32'd8);
        b0 = beat_total;
        host_write(8'h08, 32'h4000_0000);
        wait_done("R6 burst write done");
        chk("R4 burst of 8 beats", beat_total - b0, 32'd8);
        for (int i = 0; i < 8; i++) begin
            chk("R5 burst address", addr_log[(b0 + i) % 512], 32'h4000_0000 + 32'(4 * i));
            chk("R2 burst memory word", mem[i], 32'h1000 + i);
        end
        host_write(8'h04, 32'h4000_0000);
        wait_done("R6 burst read done");
        for (int i = 0; i < 8; i++) begin
            host_read(8'h80 + 8'(i), d);
            chk("R3 burst capture entry", d, 32'h1000 + i);
        end
    endtask

    task automatic t_status();
        logic [31:0] d;
        wait_cfg = 3;
        host_write(8'h02, 32'd0);
        host_write(8'h04, 32'h4000_0000);
        host_read(8'h00, d);
        chk("R7 status cleared on launch", {31'b0, d[0]}, 32'd0);
        wait_done("R6 status back to 1");
    endtask

    task automatic t_clamp();
        logic [31:0] d;
        int b0;
        wait_cfg = 0;
        for (int i = 0; i < 64; i++) host_write(8'hC0 + 8'(i), 32'h6000 + i);
        host_write(8'h02, 32'd100);
        host_read(8'h02, d); chk("R1 size readback", d, 32'd100);
        b0 = beat_total;
        host_write(8'h08, 32'h6000_0100);
        wait_done("R6 clamp done");
        repeat (10) @(negedge clk);
        chk("R8 clamped beats", beat_total - b0, 32'd64);
        chk("R8 last address", addr_log[(b0 + 63) % 512], 32'h6000_01FC);
        chk("R8 last word", mem[127], 32'h6000 + 63);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        int b0;
        wait_cfg = 5;
        host_write(8'h02, 32'd4);
        b0 = beat_total;
        host_write(8'h04, 32'h4000_0000);
        host_write(8'h08, 32'h6000_0400);
        host_write(8'h04, 32'h4000_0300);
        wait_done("R6 busy test done");
        repeat (20) @(negedge clk);
        chk("R10 beats unchanged", beat_total - b0, 32'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R10 address kept", addr_log[(b0 + i) % 512], 32'h4000_0000 + 32'(4 * i));
            chk("R10 still a read", {31'b0, we_log[(b0 + i) % 512]}, 32'd0);
            host_read(8'h80 + 8'(i), d);
            chk("R10 capture data", d, 32'h1000 + i);
        end
    endtask

    task automatic t_waits();
        logic [31:0] d;
        wait_cfg = 7;
        host_write(8'h02, 32'd3);
        host_write(8'h04, 32'h4000_0200);
        wait_done("R6 slow read done");
        for (int i = 0; i < 3; i++) begin
            host_read(8'h80 + 8'(i), d);
            chk("R9 data under wait states", d, pat(32'h4000_0200 + 32'(4 * i)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_status();
        t_clamp();
        t_busy_ignore();
        t_waits();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule